// File: doc/BRIEF.md
# Value-Variance Soft-Error Checker

This block watches the 32-bit results that instructions produce and flags a result whose change from the previous result of the same instruction does not fit that instruction's learned pattern of change. A direct-mapped table indexed by the instruction address holds, per entry, an address tag, a small saturating confidence counter, a per-chunk change mask and the last result seen. Each new result is XORed with the stored last result. The difference is compressed into one bit per fixed-width chunk, and that bit says whether anything in the chunk changed.

A chunk that has never changed for an instruction is treated as stable. If a trusted entry sees a stable chunk change, the block raises an alert one cycle later, together with the address of the offending instruction. Chunks already known to vary are not checked, so that part of the coverage is given up. After each check the entry learns: its confidence rises on results that fit and drops to zero on a mismatch, the mismatch widens the mask, and the last value always takes the new result. Only the address is needed to start the lookup, so the check can run beside execution and stay off the pipeline's critical path.

Top module: `vv_check`

## Requirements
- R1: After reset `alert` and `alert_pc` are 0 and every table entry is empty, so the first result seen for any address is treated as a miss.
- R2: The table has 64 entries. The entry index is `in_pc[5:0]` and the tag is `in_pc[31:6]`. A different tag at the same index is a miss and replaces the entry.
- R3: The change encoding has 8 bits. Bit k is 1 when any bit of `in_result ^ last` in positions 4k+3 down to 4k is 1.
- R4: On a miss the entry is filled with the new tag and result, a mask of all zeros and confidence 0, and no alert is raised.
- R5: On a hit whose encoding sets no bit outside the stored mask, confidence rises by one and saturates at 3.
- R6: On a hit whose encoding sets a bit that the stored mask has at 0, confidence becomes 0 and the encoding is ORed into the mask.
- R7: `alert` is 1 in the cycle after an input exactly when that input was valid, hit, had confidence 3 and broke the mask as in R6.
- R8: Changes confined to chunks whose mask bit is 1 never raise an alert.
- R9: Every valid input replaces the stored last value with its result, whether it hits, misses or breaks the mask.
- R10: `alert_pc` is the PC of the most recent valid input, registered one cycle after it. An input with `in_valid` low changes neither the table nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A result is presented this cycle |
| in_pc | input | 32 | Address of the instruction that produced the result |
| in_result | input | 32 | The instruction's result value |
| alert | output | 1 | Suspected error in the previous cycle's result |
| alert_pc | output | 32 | PC of the most recent valid input |

## Verification
Two functions can fall in the same cycle. An alert can be issued in the same cycle that the mask is widened and the confidence cleared. A result for an address can also arrive in the cycle right after the entry was written by the previous result. The bench provokes both with back-to-back results for one address: it trains the entry to full confidence, breaks the mask, and then sends the same kind of change again at once. The second change must not alert, which shows that the widened mask and the cleared confidence were both visible on the next cycle. A behavioural model in the bench predicts `alert` and `alert_pc` for every clock, and the bench compares them on every clock.

// File: rtl/vv_check.sv
module vv_check #(
  parameter int PC_W    = 32,
  parameter int DATA_W  = 32,
  parameter int CHUNKS  = 8,
  parameter int ENTRIES = 64,
  parameter int CONF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [DATA_W-1:0] in_result,
  output logic              alert,
  output logic [PC_W-1:0]   alert_pc
);
  localparam int CHUNK_W = DATA_W / CHUNKS;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int TAG_W   = PC_W - IDX_W;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [CONF_W-1:0] CONF_ONE = {{(CONF_W-1){1'b0}}, 1'b1};

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [CONF_W-1:0]  conf_q [ENTRIES];
  logic [CHUNKS-1:0]  mask_q [ENTRIES];
  logic [DATA_W-1:0]  last_q [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [DATA_W-1:0] diff;
  logic [CHUNKS-1:0] enc, mask_rd;
  logic [CONF_W-1:0] conf_rd;
  logic              hit, viol, fire;

  assign idx     = in_pc[IDX_W-1:0];
  assign tag     = in_pc[PC_W-1:IDX_W];
  assign mask_rd = mask_q[idx];
  assign conf_rd = conf_q[idx];
  assign diff    = in_result ^ last_q[idx];

  for (genvar k = 0; k < CHUNKS; k++) begin : g_enc
    assign enc[k] = |diff[k*CHUNK_W +: CHUNK_W];
  end

  assign hit  = vld_q[idx] && (tag_q[idx] == tag);
  assign viol = |(enc & ~mask_rd);
  assign fire = in_valid && hit && viol && (conf_rd == CONF_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (in_valid) vld_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_n && in_valid) begin
      last_q[idx] <= in_result;
      if (!hit) begin
        tag_q[idx]  <= tag;
        mask_q[idx] <= '0;
        conf_q[idx] <= '0;
      end else if (viol) begin
        mask_q[idx] <= mask_rd | enc;
        conf_q[idx] <= '0;
      end else if (conf_rd != CONF_MAX) begin
        conf_q[idx] <= conf_rd + CONF_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alert    <= 1'b0;
      alert_pc <= '0;
    end else begin
      alert <= fire;
      if (in_valid) alert_pc <= in_pc;
    end
  end

  // R7
  alert_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> $past(in_valid));

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hit) |=> !alert);

  // R8
  fit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit && !viol) |=> !alert);

  // R7
  low_conf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit && conf_rd != CONF_MAX) |=> !alert);

  // R10
  alert_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> (alert_pc == $past(in_pc)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!alert && $stable(alert_pc)));
endmodule

// File: tb/vv_check_tb.sv
`timescale 1ns/1ps
module vv_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_pc = '0;
  logic [31:0] in_result = '0;
  logic        alert;
  logic [31:0] alert_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [25:0] m_tag [int];
  int          m_conf[int];
  logic [7:0]  m_mask[int];
  logic [31:0] m_last[int];
  logic        exp_alert = 1'b0;
  logic [31:0] exp_pc = '0;

  always #2.5 clk = ~clk;

  vv_check u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
    .in_result(in_result), .alert(alert), .alert_pc(alert_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] pc, input logic [31:0] res, input string req);
    int i;
    logic [31:0] d;
    logic [7:0] e;
    exp_alert = 1'b0;
    if (v) begin
      i = int'(pc % 64);
      if (m_tag.exists(i) && m_tag[i] == pc[31:6]) begin
        d = res ^ m_last[i];
        e = '0;
        for (int b = 0; b < 32; b++) if (d[b]) e[b/4] = 1'b1;
        if ((e & ~m_mask[i]) != 0) begin
          exp_alert = (m_conf[i] == 3);
          m_conf[i] = 0;
          m_mask[i] = m_mask[i] | e;
        end else if (m_conf[i] < 3) m_conf[i] = m_conf[i] + 1;
      end else begin
        m_tag[i] = pc[31:6];
        m_conf[i] = 0;
        m_mask[i] = '0;
      end
      m_last[i] = res;
      exp_pc = pc;
    end
    in_valid = v; in_pc = pc; in_result = res;
    @(posedge clk); #1;
    check(req, {31'b0, alert}, {31'b0, exp_alert}, "alert");
    check(req, alert_pc, exp_pc, "alert_pc");
  endtask

  localparam logic [31:0] PA = 32'h1000_0004;
  localparam logic [31:0] PB = 32'h2000_0004;
  localparam logic [31:0] PC2 = 32'h0000_0817;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", {31'b0, alert}, 32'd0, "alert at reset");
    check("R1", alert_pc, 32'd0, "alert_pc at reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R4 first access is a miss, large value no alert
    step(1, PA, 32'hDEAD_0100, "R4");
    // R3 R6 first change in chunk0 learns mask
    step(1, PA, 32'hDEAD_0101, "R6");
    // R5 fitting changes build confidence, saturate
    for (int n = 0; n < 5; n++) step(1, PA, 32'hDEAD_0102 + n, "R5");
    // R7 trusted entry, stable chunk 7 changes: alert
    step(1, PA, 32'h5EAD_0106, "R7");
    // back-to-back: same kind of change now in mask, conf 0
    step(1, PA, 32'hDEAD_0106, "R6");
    // R10 idle cycles with garbage change nothing
    step(0, PA, 32'hFFFF_FFFF, "R10");
    step(0, PB, 32'h0, "R10");
    // R9 last value taken from the violating result chain
    step(1, PA, 32'h5EAD_0107, "R9");
    step(1, PA, 32'hDEAD_0105, "R8");
    step(1, PA, 32'h5EAD_0100, "R8");
    // R3 chunk boundary: bit 3 stays in chunk0, bit 4 leaves it
    step(1, PA, 32'h5EAD_0108, "R3");
    step(1, PA, 32'h5EAD_0118, "R3");
    // R2 alias at same index evicts, then original address misses
    step(1, PB, 32'h0000_0000, "R2");
    step(1, PB, 32'h0000_0001, "R2");
    step(1, PA, 32'hFFFF_FFFF, "R2");
    // second address, interleaved with first
    step(1, PC2, 32'h0000_00F0, "R4");
    for (int n = 0; n < 4; n++) begin
      step(1, PC2, 32'h0000_00F0 ^ (32'h1 << (n % 2)), "R5");
      step(1, PA, 32'hFFFF_FFF0 + n, "R5");
    end
    step(1, PC2, 32'h0000_80F2, "R7");
    step(1, PA, 32'h7FFF_FFF3, "R7");
    step(1, PA, 32'h7FFF_FFF3, "R5");
    step(1, PC2, 32'h0000_80F2, "R9");
    // R8 trained entry, change only learned chunks
    for (int n = 0; n < 4; n++) step(1, PC2, 32'h0000_80F2 ^ (n[31:0] << 12), "R8");
    step(1, PC2, 32'h0001_30F1, "R7");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule